// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block performs a single write access to an external static memory. When it accepts a start request, it captures the address, data, byte enables and chip-select index. It then drives these values for a programmed number of controller clocks, the total cycle. Inside that window it lowers an active-low write strobe and an active-low chip-select strobe. Each strobe has its own start offset and its own length.

Each chip-select line has its own set of timings, given as whole clock counts. The hold time after each strobe is not programmed. It is whatever remains of the total cycle after that strobe's setup and pulse. A one-clock done pulse marks the last clock of the access, and the next access may be accepted on the clock after it.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held and after it releases, busy_o and done_o are 0, we_n_o is 1 and every bit of cs_n_o is 1.
- R2: A start request accepted while idle latches addr_i, data_i, bsel_i and cs_sel_i. From the next clock, addr_o, data_o and bsel_o show the latched values and stay unchanged for the whole access, even if the inputs change.
- R3: An access lasts T clocks, numbered 0 to T-1 from the clock after acceptance. busy_o is 1 in every one of these clocks. done_o is 1 only in clock T-1, and busy_o is 0 in the clock after it.
- R4: we_n_o is 0 exactly in clocks k with we_setup <= k < we_setup + we_pulse, and 1 otherwise. The hold time is therefore T - we_setup - we_pulse.
- R5: Only bit cs_sel of cs_n_o can be 0. That bit is 0 exactly in clocks k with cs_setup <= k < cs_setup + cs_pulse. All other bits stay 1.
- R6: If setup + pulse exceeds T for a strobe, that strobe returns high at the end of clock T-1. If setup >= T, that strobe never goes low.
- R7: A programmed total of 0 behaves as a total of 1.
- R8: A start request during an access, including in the done clock, is ignored. The outputs, the access length and the idle state that follows are unchanged.
- R9: Each chip-select index uses its own slice of the timing inputs. Slice i occupies bits [i*6 +: 6] of each timing vector.
- R10: A start request held in the clock right after done is accepted. The new access begins on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | request one write access |
| cs_sel_i | input | 2 | chip-select index of the request |
| addr_i | input | 20 | write address |
| data_i | input | 16 | write data |
| bsel_i | input | 2 | byte enables, active high |
| we_setup_i | input | 24 | write-strobe setup per chip select, 6 bits each |
| we_pulse_i | input | 24 | write-strobe pulse per chip select |
| cs_setup_i | input | 24 | chip-select setup per chip select |
| cs_pulse_i | input | 24 | chip-select pulse per chip select |
| total_i | input | 24 | total cycle length per chip select |
| busy_o | output | 1 | access in progress |
| done_o | output | 1 | last clock of the access |
| addr_o | output | 20 | latched address |
| data_o | output | 16 | latched data |
| bsel_o | output | 2 | latched byte enables |
| we_n_o | output | 1 | write strobe, active low |
| cs_n_o | output | 4 | chip-select lines, active low |

## Verification
Clock index 0 of an access is the clock after the edge that accepts the request. busy_o, addr_o, data_o, bsel_o and both strobes reflect index k during clock k, and done_o rises in clock T-1. The bench drives start at a falling edge and then samples every output at each later falling edge. It compares the outputs at index k with windows it computes from the programmed setup, pulse and total values. It also checks the idle clock after each access, which confirms that an ignored request did not start a new access and that a back-to-back request starts exactly one clock later.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int CNT_W = 6;
  typedef logic [CNT_W-1:0] cnt_t;
  // strobe windows as [beg, end) clock indices, last = T-1
  typedef struct packed {
    cnt_t we_beg;
    cnt_t we_end;
    cnt_t cs_beg;
    cnt_t cs_end;
    cnt_t last;
  } win_t;
endpackage

// File: rtl/sws_timing_sel.sv
module sws_timing_sel
  import sws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSI_W  = 2
) (
  input  logic [NUM_CS*CNT_W-1:0] we_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] we_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] cs_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] cs_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] total_i,
  input  logic [CSI_W-1:0]        sel_i,
  output win_t                    win_o
);
  function automatic cnt_t win_end(cnt_t beg, cnt_t pulse, cnt_t tot);
    logic [CNT_W:0] sum;
    sum = {1'b0, beg} + {1'b0, pulse};
    if (beg >= tot)              return beg;
    else if (sum > {1'b0, tot})  return tot;
    else                         return sum[CNT_W-1:0];
  endfunction

  win_t win_all [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    cnt_t tot;
    always_comb begin
      tot = (total_i[g*CNT_W +: CNT_W] == '0) ? cnt_t'(1) : total_i[g*CNT_W +: CNT_W];
      win_all[g].we_beg = we_setup_i[g*CNT_W +: CNT_W];
      win_all[g].we_end = win_end(we_setup_i[g*CNT_W +: CNT_W], we_pulse_i[g*CNT_W +: CNT_W], tot);
      win_all[g].cs_beg = cs_setup_i[g*CNT_W +: CNT_W];
      win_all[g].cs_end = win_end(cs_setup_i[g*CNT_W +: CNT_W], cs_pulse_i[g*CNT_W +: CNT_W], tot);
      win_all[g].last   = tot - cnt_t'(1);
    end
  end

  always_comb begin
    win_o = win_all[0];
    for (int i = 1; i < NUM_CS; i++)
      if (sel_i == CSI_W'(i)) win_o = win_all[i];
  end
endmodule

// File: rtl/sws_cycle_ctrl.sv
module sws_cycle_ctrl
  import sws_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  cnt_t last_i,
  output logic accept_o,
  output logic busy_o,
  output cnt_t cnt_o,
  output logic done_o
);
  logic busy_q;
  cnt_t cnt_q;

  assign accept_o = start_i & ~busy_q;
  assign done_o   = busy_q && (cnt_q == last_i);
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == last_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_q);
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= last_i);
  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q && (cnt_q == $past(cnt_q) + cnt_t'(1)));
endmodule

// File: rtl/sws_strobe_gen.sv
module sws_strobe_gen
  import sws_pkg::*;
(
  input  logic busy_i,
  input  cnt_t cnt_i,
  input  cnt_t beg_i,
  input  cnt_t end_i,
  output logic strobe_n_o
);
  assign strobe_n_o = ~(busy_i && (cnt_i >= beg_i) && (cnt_i < end_i));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BSEL_W = 2,
  localparam int CSI_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int TW    = NUM_CS * CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CSI_W-1:0]  cs_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BSEL_W-1:0] bsel_i,
  input  logic [TW-1:0]     we_setup_i,
  input  logic [TW-1:0]     we_pulse_i,
  input  logic [TW-1:0]     cs_setup_i,
  input  logic [TW-1:0]     cs_pulse_i,
  input  logic [TW-1:0]     total_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BSEL_W-1:0] bsel_o,
  output logic              we_n_o,
  output logic [NUM_CS-1:0] cs_n_o
);
  win_t              win_sel, win_q;
  logic              accept, cs_strobe_n;
  cnt_t              cnt;
  logic [CSI_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BSEL_W-1:0] bsel_q;

  sws_timing_sel #(.NUM_CS(NUM_CS), .CSI_W(CSI_W)) u_tsel (
    .we_setup_i(we_setup_i), .we_pulse_i(we_pulse_i),
    .cs_setup_i(cs_setup_i), .cs_pulse_i(cs_pulse_i),
    .total_i(total_i), .sel_i(cs_sel_i), .win_o(win_sel)
  );

  sws_cycle_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .last_i(win_q.last),
    .accept_o(accept), .busy_o(busy_o), .cnt_o(cnt), .done_o(done_o)
  );

  // timing, address and data all captured on the accepting edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      cs_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      bsel_q <= '0;
    end else if (accept) begin
      win_q  <= win_sel;
      cs_q   <= cs_sel_i;
      addr_q <= addr_i;
      data_q <= data_i;
      bsel_q <= bsel_i;
    end
  end

  sws_strobe_gen u_we (
    .busy_i(busy_o), .cnt_i(cnt), .beg_i(win_q.we_beg), .end_i(win_q.we_end),
    .strobe_n_o(we_n_o)
  );
  sws_strobe_gen u_cs (
    .busy_i(busy_o), .cnt_i(cnt), .beg_i(win_q.cs_beg), .end_i(win_q.cs_end),
    .strobe_n_o(cs_strobe_n)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign cs_n_o[g] = cs_strobe_n | (cs_q != CSI_W'(g));
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign bsel_o = bsel_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o) && $stable(data_o) && $stable(bsel_o));
  // R5
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R1
  idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> we_n_o && (&cs_n_o) && !done_o);
  // R6
  last_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> we_n_o && (&cs_n_o));
endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;
  import sws_pkg::*;
  localparam int NUM_CS = 4, ADDR_W = 20, DATA_W = 16, BSEL_W = 2, CW = CNT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start = 1'b0;
  logic [1:0]        cs_sel = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [BSEL_W-1:0] bsel = '0;
  logic [NUM_CS*CW-1:0] we_s, we_p, cs_s, cs_p, tot;
  logic busy, done, we_n;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] data_o;
  logic [BSEL_W-1:0] bsel_o;
  logic [NUM_CS-1:0] cs_n;

  int ws[NUM_CS], wp[NUM_CS], css[NUM_CS], csp[NUM_CS], tt[NUM_CS];
  int total = 0, bad = 0;
  bit finished = 0;

  always_comb
    for (int i = 0; i < NUM_CS; i++) begin
      we_s[i*CW +: CW] = CW'(ws[i]);
      we_p[i*CW +: CW] = CW'(wp[i]);
      cs_s[i*CW +: CW] = CW'(css[i]);
      cs_p[i*CW +: CW] = CW'(csp[i]);
      tot[i*CW +: CW]  = CW'(tt[i]);
    end

  sram_wr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cs_sel_i(cs_sel),
    .addr_i(addr), .data_i(data), .bsel_i(bsel),
    .we_setup_i(we_s), .we_pulse_i(we_p), .cs_setup_i(cs_s), .cs_pulse_i(cs_p),
    .total_i(tot), .busy_o(busy), .done_o(done), .addr_o(addr_o), .data_o(data_o),
    .bsel_o(bsel_o), .we_n_o(we_n), .cs_n_o(cs_n)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wend(int s, int p, int t);
    if (s >= t) return s;
    return (s + p > t) ? t : s + p;
  endfunction

  task automatic check_idle(string req);
    chk(req, "idle busy", busy, 0);
    chk(req, "idle done", done, 0);
    chk(req, "idle we_n", we_n, 1);
    chk(req, "idle cs_n", cs_n, 4'hF);
  endtask

  // caller is at a falling edge; start is accepted on the next rising edge
  task automatic run_cycle(int cs, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                           logic [BSEL_W-1:0] b, int intrude, string req);
    int t, we_e, cs_e;
    t    = (tt[cs] == 0) ? 1 : tt[cs];
    we_e = wend(ws[cs], wp[cs], t);
    cs_e = wend(css[cs], csp[cs], t);
    start = 1'b1; cs_sel = 2'(cs); addr = a; data = d; bsel = b;
    @(negedge clk);
    for (int k = 0; k < t; k++) begin
      if (k == intrude) begin
        start = 1'b1; addr = ~a; data = ~d; cs_sel = 2'(cs + 1);
      end else begin
        start = 1'b0; addr = a ^ 20'h5; data = d ^ 16'h3;
      end
      begin
        bit we_low, cs_low;
        logic [NUM_CS-1:0] cs_exp;
        we_low = (k >= ws[cs]) && (k < we_e);
        cs_low = (k >= css[cs]) && (k < cs_e);
        cs_exp = '1;
        if (cs_low) cs_exp[cs] = 1'b0;
        chk(req, $sformatf("busy k=%0d", k), busy, 1);
        chk(req, $sformatf("done k=%0d", k), done, (k == t - 1) ? 1 : 0);
        chk(req, $sformatf("we_n k=%0d", k), we_n, we_low ? 0 : 1);
        chk(req, $sformatf("cs_n k=%0d", k), cs_n, cs_exp);
        chk(req, $sformatf("addr k=%0d", k), addr_o, a);
        chk(req, $sformatf("data k=%0d", k), data_o, d);
        chk(req, $sformatf("bsel k=%0d", k), bsel_o, b);
      end
      @(negedge clk);
    end
    start = 1'b0;
    check_idle(req);
  endtask

  task automatic set_cs(int cs, int s1, int p1, int s2, int p2, int t);
    ws[cs] = s1; wp[cs] = p1; css[cs] = s2; csp[cs] = p2; tt[cs] = t;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic test_basic();       // R2 R3 R4 R5
    run_cycle(0, 20'hABCDE, 16'h1234, 2'b01, -1, "R4");
  endtask

  task automatic test_per_cs();      // R9
    run_cycle(1, 20'h00011, 16'hBEEF, 2'b10, -1, "R9");
  endtask

  task automatic test_clamp();       // R6
    run_cycle(2, 20'h77777, 16'h0F0F, 2'b11, -1, "R6");
  endtask

  task automatic test_zero_total();  // R7
    run_cycle(3, 20'h12345, 16'hCAFE, 2'b11, -1, "R7");
  endtask

  task automatic test_ignore();      // R8 mid-access and in the done clock
    run_cycle(0, 20'h0AAAA, 16'h5555, 2'b10, 2, "R8");
    run_cycle(1, 20'h0BBBB, 16'h6666, 2'b01, 3, "R8");
  endtask

  task automatic test_back_to_back(); // R10 no gap beyond the idle clock
    run_cycle(1, 20'h10101, 16'h1111, 2'b01, -1, "R10");
    run_cycle(0, 20'h20202, 16'h2222, 2'b10, -1, "R10");
    run_cycle(2, 20'h30303, 16'h3333, 2'b11, -1, "R10");
  endtask

  task automatic test_long();        // R6 at the largest total
    set_cs(0, 10, 60, 0, 63, 63);
    @(negedge clk);
    run_cycle(0, 20'hFFFFF, 16'hFFFF, 2'b11, -1, "R6");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    set_cs(0, 1, 2, 0, 5, 6);
    set_cs(1, 0, 1, 2, 1, 4);
    set_cs(2, 3, 9, 7, 2, 5);
    set_cs(3, 0, 1, 0, 3, 0);
    test_reset();
    test_basic();
    test_per_cs();
    test_clamp();
    test_zero_total();
    test_ignore();
    test_back_to_back();
    test_long();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule